// File: doc/BRIEF.md
# Taken-Branch Target Buffer with Fetch Redirect

This block sits in the instruction fetch stage. It produces the next fetch address in the same cycle that the current fetch address is presented. It holds a small fully associative set of branches that are known to be taken, each stored with its full word address and its target. A fetch address that matches a stored branch is sent on to that branch's target. Any other fetch address is followed by the next sequential word.

A later pipeline stage reports every resolved branch to the block. The report gives the branch address, the actual direction, the actual target, and whether fetch found the branch in the buffer. From this report the block adds an entry when a branch missed the buffer and resolved as taken. It removes an entry when a found branch turns out to have been predicted wrongly. Whenever fetch went the wrong way, it raises a one-cycle restart pulse that carries the correct address. A found branch that was predicted correctly causes no restart and no change to the buffer.

Top module: `btb_redirect`

## Requirements
- R1: After reset no entry is valid, so every fetch address misses (hit=0, next_pc=fetch_pc+4).
- R2: When no valid entry matches, hit is 0 and next_pc equals fetch_pc+4 in the same cycle.
- R3: When a valid entry's tag equals fetch_pc[31:2], hit is 1 and next_pc equals {stored target, 2'b00} in the same cycle, combinationally.
- R4: The tag comparison covers all 30 upper address bits, so an address that differs from a stored branch only in bit 31 misses.
- R5: A resolve with found=0 and taken=1 stores the branch. A fetch of that address in the resolve cycle still misses, and fetches from the following cycle onward hit with the new target.
- R6: A resolve with found=0 and taken=1 makes restart 1 in the cycle after the resolve, with restart_pc equal to the actual target.
- R7: A resolve with found=1 and taken=0 makes restart 1 in the next cycle with restart_pc = branch address + 4, and it removes any matching entry.
- R8: A resolve with found=1 and taken=1 where no entry matches, or where the stored target differs from the actual target, makes restart 1 in the next cycle with restart_pc = actual target, and it removes any matching entry.
- R9: A resolve with found=1 and taken=1 whose stored target equals the actual target raises no restart and leaves the entry in place.
- R10: A resolve with found=0 and taken=0 raises no restart and leaves the buffer unchanged.
- R11: An insert goes to the lowest-indexed invalid slot. When all 16 slots are valid, it replaces slots in round-robin order. The round-robin pointer starts at slot 0 after reset and advances only when it is used, so the 17th distinct insert after reset evicts the 1st branch inserted and the 18th evicts the 2nd.
- R12: restart lasts a single cycle. It is 0 in any cycle that does not directly follow a resolve calling for a restart.
- R13: An insert for an address that is already stored overwrites that entry's target and creates no second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Current fetch address (word aligned) |
| hit | output | 1 | Fetch address found in the buffer |
| next_pc | output | 32 | Next fetch address: stored target on a hit, fetch_pc+4 otherwise |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Branch was actually taken |
| res_target | input | 32 | Actual taken target of the branch |
| res_found | input | 1 | Fetch had found this branch in the buffer |
| restart | output | 1 | One-cycle pulse: fetch went the wrong way |
| restart_pc | output | 32 | Correct fetch address that goes with restart |

## Verification
hit and next_pc are combinational, so the bench drives fetch_pc on the falling edge and compares them a short delay later, before any buffer update takes place. The buffer update and restart/restart_pc come from the clock edge after a resolve. The bench therefore advances its own reference buffer at that edge and compares the restart outputs just after it. An insert and a lookup of the same address fall in one step, and the lookup is checked against the contents before the update, which covers the rule that a new entry is not seen in its own cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_WRITE  = 2'd1,
        UPD_REMOVE = 2'd2
    } upd_kind_e;
endpackage

// File: rtl/btb_cam.sv
module btb_cam #(
    parameter int N  = 16,
    parameter int TW = 30
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][TW-1:0] tags,
    input  logic [N-1:0][TW-1:0] tgts,
    input  logic [TW-1:0]        key,
    output logic [N-1:0]         match,
    output logic [TW-1:0]        data
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = vld[i] && (tags[i] == key);
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) data = data | tgts[i];
        end
    end
endmodule

// File: rtl/btb_pick.sv
module btb_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vld,
    input  logic [N-1:0]  match,
    input  logic [IW-1:0] rr,
    output logic [IW-1:0] slot,
    output logic          evict
);
    logic [IW-1:0] free_idx;
    logic          have_free;
    logic [IW-1:0] match_idx;

    always_comb begin
        free_idx  = '0;
        have_free = 1'b0;
        match_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx  = IW'(i);
                have_free = 1'b1;
            end
            if (match[i]) match_idx = IW'(i);
        end
        if (|match) begin
            slot  = match_idx;
            evict = 1'b0;
        end else if (have_free) begin
            slot  = free_idx;
            evict = 1'b0;
        end else begin
            slot  = rr;
            evict = 1'b1;
        end
    end
endmodule

// File: rtl/btb_redirect.sv
module btb_redirect #(
    parameter int N  = 16,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] fetch_pc,
    output logic          hit,
    output logic [PW-1:0] next_pc,
    input  logic          res_valid,
    input  logic [PW-1:0] res_pc,
    input  logic          res_taken,
    input  logic [PW-1:0] res_target,
    input  logic          res_found,
    output logic          restart,
    output logic [PW-1:0] restart_pc
);
    import btb_pkg::*;

    localparam int TW = PW - 2;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][TW-1:0] tag;
        logic [N-1:0][TW-1:0] tgt;
        logic [IW-1:0]        rr;
        logic                 rs;
        logic [PW-1:0]        rs_pc;
    } state_t;

    state_t st_q, st_d;

    logic [N-1:0]  f_match;
    logic [TW-1:0] f_tgt;
    logic [N-1:0]  r_match;
    logic [TW-1:0] r_tgt;
    logic [IW-1:0] w_slot;
    logic          w_evict;
    upd_kind_e     upd;

    btb_cam #(.N(N), .TW(TW)) u_fetch_cam (
        .vld(st_q.vld), .tags(st_q.tag), .tgts(st_q.tgt),
        .key(fetch_pc[PW-1:2]), .match(f_match), .data(f_tgt)
    );

    btb_cam #(.N(N), .TW(TW)) u_res_cam (
        .vld(st_q.vld), .tags(st_q.tag), .tgts(st_q.tgt),
        .key(res_pc[PW-1:2]), .match(r_match), .data(r_tgt)
    );

    btb_pick #(.N(N), .IW(IW)) u_pick (
        .vld(st_q.vld), .match(r_match), .rr(st_q.rr),
        .slot(w_slot), .evict(w_evict)
    );

    assign hit     = |f_match;
    assign next_pc = hit ? {f_tgt, 2'b00} : fetch_pc + PW'(4);

    always_comb begin
        st_d    = st_q;
        st_d.rs = 1'b0;
        upd     = UPD_NONE;
        if (res_valid) begin
            if (res_found) begin
                if (!res_taken) begin
                    st_d.rs    = 1'b1;
                    st_d.rs_pc = res_pc + PW'(4);
                    upd        = UPD_REMOVE;
                end else if (!(|r_match) || (r_tgt != res_target[PW-1:2])) begin
                    st_d.rs    = 1'b1;
                    st_d.rs_pc = res_target;
                    upd        = UPD_REMOVE;
                end
            end else if (res_taken) begin
                st_d.rs    = 1'b1;
                st_d.rs_pc = res_target;
                upd        = UPD_WRITE;
            end
        end

        case (upd)
            UPD_REMOVE: st_d.vld = st_q.vld & ~r_match;
            UPD_WRITE: begin
                st_d.vld[w_slot] = 1'b1;
                st_d.tag[w_slot] = res_pc[PW-1:2];
                st_d.tgt[w_slot] = res_target[PW-1:2];
                if (w_evict) begin
                    st_d.rr = (st_q.rr == IW'(N - 1)) ? '0 : st_q.rr + IW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld   <= '0;
            st_q.tag   <= '0;
            st_q.tgt   <= '0;
            st_q.rr    <= '0;
            st_q.rs    <= 1'b0;
            st_q.rs_pc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign restart    = st_q.rs;
    assign restart_pc = st_q.rs_pc;
endmodule

// File: rtl/btb_redirect_chk.sv
module btb_redirect_chk #(
    parameter int N  = 16,
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] fetch_pc,
    input logic          hit,
    input logic [PW-1:0] next_pc,
    input logic          res_valid,
    input logic [PW-1:0] res_pc,
    input logic          res_taken,
    input logic [PW-1:0] res_target,
    input logic          res_found,
    input logic          restart,
    input logic [PW-1:0] restart_pc,
    input logic [N-1:0]  f_match
);
    a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> next_pc == fetch_pc + PW'(4));

    a_r5_insert_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(res_valid && !res_found && res_taken) && fetch_pc[PW-1:2] == $past(res_pc[PW-1:2]))
        |-> (hit && next_pc[PW-1:2] == $past(res_target[PW-1:2])));

    a_r6_taken_miss_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(res_valid && !res_found && res_taken) |-> (restart && restart_pc == $past(res_target)));

    a_r7_not_taken_found: assert property (@(posedge clk) disable iff (!rst_n)
        $past(res_valid && res_found && !res_taken) |-> (restart && restart_pc == $past(res_pc) + PW'(4)));

    a_r10_quiet_miss: assert property (@(posedge clk) disable iff (!rst_n)
        $past(res_valid && !res_found && !res_taken) |-> !restart);

    a_r12_restart_cause: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> $past(res_valid));

    a_r13_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(f_match));
endmodule

bind btb_redirect btb_redirect_chk #(.N(N), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hit(hit), .next_pc(next_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_found(res_found), .restart(restart),
    .restart_pc(restart_pc), .f_match(f_match)
);

// File: tb/btb_redirect_test.sv
module btb_redirect_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        hit;
    logic [31:0] next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        res_found = 1'b0;
    logic        restart;
    logic [31:0] restart_pc;

    int checks = 0;
    int fails  = 0;

    logic        m_vld [N];
    logic [29:0] m_tag [N];
    logic [29:0] m_tgt [N];
    int          m_rr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    btb_redirect uut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hit(hit), .next_pc(next_pc),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_found(res_found),
        .restart(restart), .restart_pc(restart_pc)
    );

    function automatic int m_find(logic [31:0] pc);
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && m_tag[i] == pc[31:2]) return i;
        end
        return -1;
    endfunction

    function automatic int m_free();
        for (int i = 0; i < N; i++) begin
            if (!m_vld[i]) return i;
        end
        return -1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        res_valid = 1'b0;
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        m_rr = 0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(logic [31:0] fpc, logic rv, logic [31:0] rpc, logic rtk,
                        logic [31:0] rtg, logic rfd, string lbl);
        int          fi;
        int          ri;
        int          slot;
        logic        e_rs;
        logic [31:0] e_rpc;
        string       htag;
        string       rtag;
        @(negedge clk);
        fetch_pc = fpc; res_valid = rv; res_pc = rpc;
        res_taken = rtk; res_target = rtg; res_found = rfd;
        #1;
        fi = m_find(fpc);
        htag = (lbl != "") ? lbl : ((fi >= 0) ? "R3" : "R2");
        check(htag, {31'b0, hit}, {31'b0, fi >= 0});
        check(htag, next_pc, (fi >= 0) ? {m_tgt[fi], 2'b00} : fpc + 32'd4);

        e_rs = 1'b0; e_rpc = '0; rtag = "R12";
        if (rv) begin
            ri = m_find(rpc);
            if (rfd && !rtk) begin
                e_rs = 1'b1; e_rpc = rpc + 32'd4; rtag = "R7";
                if (ri >= 0) m_vld[ri] = 1'b0;
            end else if (rfd && rtk) begin
                if (ri < 0 || m_tgt[ri] != rtg[31:2]) begin
                    e_rs = 1'b1; e_rpc = rtg; rtag = "R8";
                    if (ri >= 0) m_vld[ri] = 1'b0;
                end else begin
                    rtag = "R9";
                end
            end else if (rtk) begin
                e_rs = 1'b1; e_rpc = rtg; rtag = "R6";
                if (ri >= 0) slot = ri;
                else if (m_free() >= 0) slot = m_free();
                else begin
                    slot = m_rr;
                    m_rr = (m_rr == N - 1) ? 0 : m_rr + 1;
                end
                m_vld[slot] = 1'b1; m_tag[slot] = rpc[31:2]; m_tgt[slot] = rtg[31:2];
            end else begin
                rtag = "R10";
            end
        end
        @(posedge clk);
        #1;
        check(rtag, {31'b0, restart}, {31'b0, e_rs});
        if (e_rs) check(rtag, restart_pc, e_rpc);
    endtask

    function automatic logic [31:0] pc_of(int k);
        return 32'h0040_0000 + 32'(k) * 32'd64;
    endfunction

    function automatic logic [31:0] tgt_of(int k, int v);
        return 32'h0080_0000 + 32'(k) * 32'd256 + 32'(v) * 32'd16;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] d;
        void'($urandom(32'd1357));
        do_reset();

        for (int k = 0; k < 4; k++) step(pc_of(k), 0, 0, 0, 0, 0, "R1");

        a = pc_of(1); b = pc_of(2); c = pc_of(3); d = pc_of(4);
        step(a, 1, a, 1, tgt_of(1, 0), 0, "R5");
        step(a, 0, 0, 0, 0, 0, "R5");
        step(a ^ 32'h8000_0000, 0, 0, 0, 0, 0, "R4");
        step(a, 1, a, 1, tgt_of(1, 0), 1, "");
        step(a, 0, 0, 0, 0, 0, "R9");
        step(a, 1, a, 1, tgt_of(1, 1), 1, "");
        step(a, 0, 0, 0, 0, 0, "R8");
        step(b, 1, b, 1, tgt_of(2, 0), 0, "");
        step(b, 1, b, 0, 0, 1, "");
        step(b, 0, 0, 0, 0, 0, "R7");
        step(c, 1, c, 0, 0, 0, "");
        step(c, 0, 0, 0, 0, 0, "R10");
        step(d, 1, d, 1, tgt_of(4, 0), 0, "");
        step(d, 1, d, 1, tgt_of(4, 1), 0, "");
        step(d, 0, 0, 0, 0, 0, "R13");
        step(d, 1, d, 0, 0, 1, "");
        step(d, 0, 0, 0, 0, 0, "R13");

        do_reset();
        for (int k = 0; k < 18; k++) step(pc_of(k + 10), 1, pc_of(k + 10), 1, tgt_of(k + 10, 0), 0, "");
        step(pc_of(10), 0, 0, 0, 0, 0, "R11");
        step(pc_of(11), 0, 0, 0, 0, 0, "R11");
        step(pc_of(12), 0, 0, 0, 0, 0, "R11");
        step(pc_of(27), 0, 0, 0, 0, 0, "R11");

        do_reset();
        for (int s = 0; s < 3000; s++) begin
            int          fk;
            int          rk;
            logic        rv;
            logic        tk;
            logic        fd;
            logic [31:0] rpc;
            fk = int'($urandom_range(0, 23));
            rk = int'($urandom_range(0, 23));
            rv = ($urandom_range(0, 9) < 6);
            tk = $urandom_range(0, 1) == 1;
            rpc = pc_of(rk);
            fd = ($urandom_range(0, 9) < 9) ? (m_find(rpc) >= 0) : ($urandom_range(0, 1) == 1);
            step(pc_of(fk), rv, rpc, tk, tgt_of(rk, int'($urandom_range(0, 1))), fd, "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule